// File: doc/BRIEF.md
# Little-Endian Sized-Access Data Memory

This block is a synchronous byte store behind a 64-bit data port. Each request carries a full 64-bit bus address, a size code that selects a 1-, 2-, 4- or 8-byte access, a write enable and 64 bits of store data. The storage answers only inside an address window that starts at a fixed base. The storage index of a byte is its bus address minus that base.

Loads collect the addressed bytes with the lowest address in the least significant position. The bits above the access width come back as zero. Stores change only the bytes the size covers. An access may start at any byte address, and a request that spans two 8-byte rows still completes in one cycle.

A request that falls outside the window or carries a size code with no meaning produces a one-cycle error response and leaves the storage untouched. Every response arrives exactly one clock after its request.

Top module: `lsm_data_mem`

## Requirements
- R1: Bus address `BASE` (default 0x8000_0000) selects storage byte 0. Any address below `BASE` gives an error response with zero data and changes nothing.
- R2: Size codes select the access width: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes and 3 gives 8 bytes.
- R3: A load places the byte at the request address in `rsp_rdata[7:0]`, the next higher address in `[15:8]`, and so on upward.
- R4: On a load, every `rsp_rdata` bit above the access width is zero.
- R5: A store of N bytes writes bytes 0..N-1 of `req_wdata`, low byte first, to N consecutive addresses. All other bytes keep their values.
- R6: Any byte alignment is accepted, including an access that crosses an 8-byte row boundary, and it completes as a single request.
- R7: When (address - `BASE`) + N exceeds `CAP_BYTES` (default 4096), the response has `rsp_err` high and zero data, and no byte is written.
- R8: Size codes 4 to 7 give an error response, and no byte is written.
- R9: `rsp_valid`, `rsp_err` and `rsp_rdata` belong to the request of the previous cycle. `rsp_err` is high for that one cycle only. `rsp_rdata` is zero for stores and for failed requests.
- R10: While `rst_n` is low, `rsp_valid`, `rsp_err` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the response registers |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 64 | Bus byte address of the request |
| req_size | input | 3 | Access size code (0..3 valid) |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data, low byte first |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Last cycle's request was rejected |
| rsp_rdata | output | 64 | Load data, zero-filled above the access width |

## Verification
Range checking and the store commit happen in the same cycle, and a store that straddles the end of the window has to be stopped there even though its leading bytes lie inside. The bench preloads the last row with known bytes and then issues a 2-byte store to the final byte. It expects an error response for that store, and a load of the final byte afterwards must still return the preloaded value. The same holds for a row-crossing store well inside the window: the two rows are written in one cycle, and a wide load over the seam must show both new bytes and the untouched neighbours around them.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   localparam int unsigned LANES  = 8;
   localparam int unsigned LANE_W = $clog2(LANES);

   // size code -> bytes touched; 0 marks a code with no meaning
   function automatic logic [3:0] size_bytes(input logic [2:0] code);
      case (code)
         3'd0:    return 4'd1;
         3'd1:    return 4'd2;
         3'd2:    return 4'd4;
         3'd3:    return 4'd8;
         default: return 4'd0;
      endcase
   endfunction
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
   import lsm_pkg::*;
#(
   parameter logic [63:0] BASE      = 64'h0000_0000_8000_0000,
   parameter int unsigned CAP_BYTES = 4096,
   localparam int unsigned ROW_W    = $clog2(CAP_BYTES / LANES)
) (
   input  logic              req_valid,
   input  logic [63:0]       req_addr,
   input  logic [2:0]        req_size,
   input  logic              req_we,
   output logic [ROW_W-1:0]  row0,
   output logic [LANE_W-1:0] lane0,
   output logic [3:0]        nbytes,
   output logic              wr_go,
   output logic              rd_go,
   output logic              bad
);
   logic [63:0] off;
   logic        above, fits, size_ok, ok;

   always_comb begin
      nbytes  = size_bytes(req_size);
      size_ok = (nbytes != 4'd0);
      above   = (req_addr >= BASE);
      off     = req_addr - BASE;
      fits    = (off <= (64'(CAP_BYTES) - 64'(nbytes)));
      ok      = size_ok && above && fits;
      lane0   = off[LANE_W-1:0];
      row0    = off[LANE_W +: ROW_W];
      wr_go   = req_valid &&  req_we && ok;
      rd_go   = req_valid && !req_we && ok;
      bad     = req_valid && !ok;
   end
endmodule

// File: rtl/lsm_lane.sv
module lsm_lane
   import lsm_pkg::*;
#(
   parameter int unsigned LANE  = 0,
   parameter int unsigned ROW_W = 9,
   localparam int unsigned DEPTH = 2 ** ROW_W
) (
   input  logic              clk,
   input  logic              wr_go,
   input  logic              rd_go,
   input  logic [ROW_W-1:0]  row0,
   input  logic [LANE_W-1:0] lane0,
   input  logic [3:0]        nbytes,
   input  logic [63:0]       wdata,
   output logic [7:0]        rd_q
);
   logic [7:0]        mem [DEPTH];
   logic [LANE_W-1:0] idx;
   logic              hit, wrap;
   logic [ROW_W-1:0]  row;
   logic [7:0]        wbyte;

   always_comb begin
      idx   = LANE_W'(LANE) - lane0;          // position of this lane in the access
      hit   = ({1'b0, idx} < nbytes);
      wrap  = (LANE_W'(LANE) < lane0);        // lane lies in the following row
      row   = row0 + ROW_W'(wrap);
      wbyte = wdata[{idx, 3'b000} +: 8];
   end

   always_ff @(posedge clk) begin
      if (wr_go && hit) mem[row] <= wbyte;
      if (rd_go)        rd_q     <= mem[row];
   end
endmodule

// File: rtl/lsm_align.sv
module lsm_align
   import lsm_pkg::*;
(
   input  logic [8*LANES-1:0] lane_bytes,
   input  logic [LANE_W-1:0]  lane0,
   input  logic [3:0]         nbytes,
   input  logic               keep,
   output logic [8*LANES-1:0] data
);
   for (genvar i = 0; i < LANES; i++) begin : g_byte
      logic [LANE_W-1:0] src;
      always_comb begin
         src = lane0 + LANE_W'(i);
         data[8*i +: 8] = (keep && (4'(i) < nbytes)) ? lane_bytes[{src, 3'b000} +: 8] : 8'h00;
      end
   end
endmodule

// File: rtl/lsm_data_mem.sv
module lsm_data_mem
   import lsm_pkg::*;
#(
   parameter logic [63:0] BASE      = 64'h0000_0000_8000_0000,
   parameter int unsigned CAP_BYTES = 4096,
   localparam int unsigned ROWS     = CAP_BYTES / LANES,
   localparam int unsigned ROW_W    = $clog2(ROWS)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [63:0] req_addr,
   input  logic [2:0]  req_size,
   input  logic        req_we,
   input  logic [63:0] req_wdata,
   output logic        rsp_valid,
   output logic        rsp_err,
   output logic [63:0] rsp_rdata
);
   if (CAP_BYTES < 2 * LANES) begin : g_cap_small
      $error("CAP_BYTES must hold at least two rows");
   end
   if ((CAP_BYTES % LANES) != 0 || (2 ** ROW_W) != ROWS) begin : g_cap_shape
      $error("CAP_BYTES must be a power of two");
   end
   if (BASE[LANE_W-1:0] != '0) begin : g_base_align
      $error("BASE must be row aligned");
   end

   logic [ROW_W-1:0]   row0;
   logic [LANE_W-1:0]  lane0, lane0_q;
   logic [3:0]         nbytes, nbytes_q;
   logic               wr_go, rd_go, bad, rd_ok_q;
   logic [8*LANES-1:0] lane_bytes;

   lsm_decode #(.BASE(BASE), .CAP_BYTES(CAP_BYTES)) u_decode (
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .req_we    (req_we),
      .row0      (row0),
      .lane0     (lane0),
      .nbytes    (nbytes),
      .wr_go     (wr_go),
      .rd_go     (rd_go),
      .bad       (bad)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      lsm_lane #(.LANE(l), .ROW_W(ROW_W)) u_lane (
         .clk    (clk),
         .wr_go  (wr_go),
         .rd_go  (rd_go),
         .row0   (row0),
         .lane0  (lane0),
         .nbytes (nbytes),
         .wdata  (req_wdata),
         .rd_q   (lane_bytes[8*l +: 8])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rd_ok_q   <= 1'b0;
         lane0_q   <= '0;
         nbytes_q  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= bad;
         rd_ok_q   <= rd_go;
         lane0_q   <= lane0;
         nbytes_q  <= nbytes;
      end
   end

   lsm_align u_align (
      .lane_bytes (lane_bytes),
      .lane0      (lane0_q),
      .nbytes     (nbytes_q),
      .keep       (rd_ok_q),
      .data       (rsp_rdata)
   );
endmodule

// File: rtl/lsm_data_mem_chk.sv
module lsm_data_mem_chk #(
   parameter logic [63:0] BASE      = 64'h0000_0000_8000_0000,
   parameter int unsigned CAP_BYTES = 4096
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [63:0] req_addr,
   input logic [2:0]  req_size,
   input logic        req_we,
   input logic        rsp_valid,
   input logic        rsp_err,
   input logic [63:0] rsp_rdata
);
   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && !rsp_err && rsp_rdata == 64'h0));

   // R9
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R9
   no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_err));

   // R9
   store_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_we) |=> (rsp_rdata == 64'h0));

   // R9
   err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == 64'h0));

   // R1
   below_base_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr < BASE) |=> rsp_err);

   // R8
   bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size > 3'd3) |=> rsp_err);

   // R7
   past_end_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr >= BASE && req_size == 3'd3
       && (req_addr - BASE) > 64'(CAP_BYTES - 8)) |=> rsp_err);

   // R4
   byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && req_size == 3'd0) |=> (rsp_rdata[63:8] == 56'h0));

   // R4
   half_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && req_size == 3'd1) |=> (rsp_rdata[63:16] == 48'h0));

   // R4
   word_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we && req_size == 3'd2) |=> (rsp_rdata[63:32] == 32'h0));
endmodule

bind lsm_data_mem lsm_data_mem_chk #(.BASE(BASE), .CAP_BYTES(CAP_BYTES)) u_chk (.*);

// File: tb/test_lsm_data_mem.sv
`timescale 1ns/100ps
module test_lsm_data_mem;
   localparam logic [63:0] BASE = 64'h0000_0000_8000_0000;
   localparam int unsigned CAP  = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic        req_we = 1'b0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [63:0] rsp_rdata;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;

   always #2.5 clk = ~clk;

   lsm_data_mem #(.BASE(BASE), .CAP_BYTES(CAP)) i_lsm_data_mem (.*);

   typedef struct packed {
      logic [23:0] tag;
      logic        we;
      logic [2:0]  sz;
      logic [15:0] off;
      logic [63:0] wd;
      logic [63:0] exp;
      logic        err;
   } vec_t;

   // preload: byte k at offset k holds value k for k < 64
   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{"R3 ", 1'b0, 3'd3, 16'h0000, 64'h0, 64'h0706050403020100, 1'b0},
      '{"R4 ", 1'b0, 3'd0, 16'h0005, 64'h0, 64'h0000000000000005, 1'b0},
      '{"R2 ", 1'b0, 3'd1, 16'h0006, 64'h0, 64'h0000000000000706, 1'b0},
      '{"R6 ", 1'b0, 3'd2, 16'h0003, 64'h0, 64'h0000000006050403, 1'b0},
      '{"R6 ", 1'b0, 3'd3, 16'h000C, 64'h0, 64'h131211100F0E0D0C, 1'b0},
      '{"R9 ", 1'b1, 3'd0, 16'h0002, 64'hFFFFFFFFFFFFFFAA, 64'h0, 1'b0},
      '{"R5 ", 1'b0, 3'd3, 16'h0000, 64'h0, 64'h0706050403AA0100, 1'b0},
      '{"R9 ", 1'b1, 3'd1, 16'h000F, 64'h123456789ABCBEEF, 64'h0, 1'b0},
      '{"R6 ", 1'b0, 3'd3, 16'h000A, 64'h0, 64'h11BEEF0E0D0C0B0A, 1'b0},
      '{"R9 ", 1'b1, 3'd2, 16'h0020, 64'h55555555DEADBEEF, 64'h0, 1'b0},
      '{"R5 ", 1'b0, 3'd3, 16'h001E, 64'h0, 64'h2524DEADBEEF1F1E, 1'b0},
      '{"R9 ", 1'b1, 3'd3, 16'h0030, 64'h0123456789ABCDEF, 64'h0, 1'b0},
      '{"R3 ", 1'b0, 3'd2, 16'h0034, 64'h0, 64'h0000000001234567, 1'b0},
      '{"R8 ", 1'b0, 3'd5, 16'h0000, 64'h0, 64'h0, 1'b1},
      '{"R8 ", 1'b1, 3'd6, 16'h003F, 64'hFFFFFFFFFFFFFFFF, 64'h0, 1'b1},
      '{"R8 ", 1'b0, 3'd0, 16'h003F, 64'h0, 64'h000000000000003F, 1'b0}
   };

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // request presented for one edge; response sampled at the next falling edge
   task automatic issue(input logic we, input logic [2:0] sz, input logic [63:0] addr,
                        input logic [63:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_size = sz; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0; req_wdata = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [63:0] pat;
      repeat (3) @(negedge clk);
      // R10: outputs quiet in reset
      check("R10", "rsp_valid", 64'(rsp_valid), 64'h0);
      check("R10", "rsp_err",   64'(rsp_err),   64'h0);
      check("R10", "rsp_rdata", rsp_rdata,      64'h0);
      rst_n = 1'b1;

      // preload bytes 0..63 with their own offsets, last row with A0..A7 (R5, R1)
      for (int r = 0; r < 8; r++) begin
         for (int b = 0; b < 8; b++) pat[8*b +: 8] = 8'(8*r + b);
         issue(1'b1, 3'd3, BASE + 64'(8*r), pat);
         check("R1", "preload err", 64'(rsp_err), 64'h0);
      end
      issue(1'b1, 3'd3, BASE + 64'(CAP - 8), 64'hA7A6A5A4A3A2A1A0);
      check("R7", "last row store err", 64'(rsp_err), 64'h0);

      for (int v = 0; v < NV; v++) begin
         issue(VECS[v].we, VECS[v].sz, BASE + 64'(VECS[v].off), VECS[v].wd);
         check(string'(VECS[v].tag), "valid", 64'(rsp_valid), 64'h1);
         check(string'(VECS[v].tag), "err",   64'(rsp_err),   64'(VECS[v].err));
         check(string'(VECS[v].tag), "data",  rsp_rdata,      VECS[v].exp);
      end

      // R1: one below the window
      issue(1'b0, 3'd0, BASE - 64'd1, '0);
      check("R1", "below base err", 64'(rsp_err), 64'h1);
      check("R1", "below base data", rsp_rdata, 64'h0);
      // R9: error lasts one cycle only
      @(negedge clk);
      check("R9", "err after idle", 64'(rsp_err), 64'h0);
      check("R9", "valid after idle", 64'(rsp_valid), 64'h0);

      // R7: last full row fits, one byte further does not
      issue(1'b0, 3'd3, BASE + 64'(CAP - 8), '0);
      check("R7", "last row err", 64'(rsp_err), 64'h0);
      check("R7", "last row data", rsp_rdata, 64'hA7A6A5A4A3A2A1A0);
      issue(1'b0, 3'd3, BASE + 64'(CAP - 7), '0);
      check("R7", "overrun err", 64'(rsp_err), 64'h1);
      check("R7", "overrun data", rsp_rdata, 64'h0);

      // R7: straddling store rejected and final byte untouched
      issue(1'b1, 3'd1, BASE + 64'(CAP - 1), 64'h0000_0000_0000_FFFF);
      check("R7", "straddle store err", 64'(rsp_err), 64'h1);
      issue(1'b0, 3'd0, BASE + 64'(CAP - 1), '0);
      check("R7", "final byte kept", rsp_rdata, 64'h0000_0000_0000_00A7);

      // R1: top of the 64-bit space
      issue(1'b0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, '0);
      check("R1", "top address err", 64'(rsp_err), 64'h1);

      // R2: base byte is index 0
      issue(1'b0, 3'd0, BASE, '0);
      check("R2", "base byte", rsp_rdata, 64'h0);
      check("R2", "base byte err", 64'(rsp_err), 64'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule